// File: doc/BRIEF.md
# Senior Store Queue

This block is a circular queue of stores. It sits between the allocation stage and the data cache write port. Each store gets a queue index when it is allocated. That same index later locates both halves of the store. The address half receives a translated tag and the data half receives the store value. The two halves may arrive in either order and in any cycle. Each entry also keeps the reorder-buffer tag of its store.

Up to NRET retirement pointers arrive each cycle, each with a ready bit. When the ready bits are a contiguous run starting at the oldest pointer, the active pointers are matched against the entries. Only an entry whose translation has completed can match. A match makes both halves senior. Senior stores drain strictly from the head to the cache, one per cycle. A store drains only when its translated address and its data are both present. The cache frees the entry by raising `cache_done`.

A small fence state machine has three states. F_IDLE goes to F_DRAIN on a fence request when older stores remain, or to F_READY when none remain. F_DRAIN counts older stores out and goes to F_READY when the last one leaves. On a flush it goes back to F_IDLE. F_READY raises the ready pulse for one cycle and always returns to F_IDLE. A flush drops every store that is not senior and pulls the tail back to just after the youngest senior store.

Top module: `sb_store_buffer`

## Requirements
- R1: An accepted allocation takes index `alloc_sbid`, which is the current tail. The tail then advances by one, modulo DEPTH (16). Address and data results are written through that same index.
- R2: An address result sets the entry's translation-valid flag and stores its tag. A retirement pointer that equals the reorder tag of an entry still lacking a translation has no effect on that entry, in that cycle or later.
- R3: Bit k of `ret_ready` goes with pointer k, which is `ret_rob[k*7 +: 7]`, and bit 0 is the oldest. The ready patterns {bit2,bit1,bit0} = 001, 011 and 111 activate pointers 0, 0–1 and 0–2 respectively. Every other pattern activates none.
- R4: A match by an active pointer marks both the address half and the data half senior. A senior store whose data is missing waits until the data arrives.
- R5: `cache_req` is high exactly when the head entry is senior and has both a valid translation and valid data. It then presents the head's index, tag and data. A younger store that is ready still waits behind the head.
- R6: `cache_done` while `cache_req` is high frees the head at that clock edge. The next entry becomes head in the following cycle. At most one store leaves per cycle.
- R7: `fence_req` in F_IDLE records the stores held before that cycle, less one if a store drains in that cycle. `fence_ready` pulses for one cycle after that count reaches zero. If the count is already zero, the pulse comes in the cycle after the request. Stores allocated in the request cycle or later are not counted. A request outside F_IDLE is ignored.
- R8: `flush` drops all entries that are not senior and sets the tail to the head plus the number of senior entries kept. Allocation, retirement and a fence request in the flush cycle are ignored. A fence in F_DRAIN returns to F_IDLE.
- R9: `sb_full` is high with DEPTH stores held, and an allocation at that time is ignored. `sb_empty` is high with none held.
- R10: After reset the queue is empty and not full, `alloc_sbid` is 0, and `cache_req` and `fence_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store this cycle |
| alloc_rob_id | input | ROBW | Reorder tag of the allocated store |
| alloc_sbid | output | IDXW | Index the next allocation receives |
| sb_full | output | 1 | Queue holds DEPTH stores |
| sb_empty | output | 1 | Queue holds no stores |
| addr_valid_in | input | 1 | Address result present |
| addr_sbid | input | IDXW | Index for the address result |
| addr_tag | input | TAGW | Translated tag |
| data_valid_in | input | 1 | Data result present |
| data_sbid | input | IDXW | Index for the data result |
| data_value | input | DATAW | Store data |
| ret_ready | input | NRET | Ready bits of the oldest instructions, bit 0 oldest |
| ret_rob | input | NRET*ROBW | Retirement pointers, pointer k in slice k |
| flush | input | 1 | Drop all non-senior stores |
| cache_req | output | 1 | Head store offered to the cache |
| cache_sbid | output | IDXW | Index of the offered store |
| cache_tag | output | TAGW | Tag of the offered store |
| cache_data | output | DATAW | Data of the offered store |
| cache_done | input | 1 | Cache has taken the offered store |
| fence_req | input | 1 | Store fence waiting for older stores |
| fence_ready | output | 1 | One-cycle pulse: older stores have left |

## Verification
The bench concentrates on orderings that a simple design gets wrong. In one, data arrives before the address. In another, a retirement pointer reaches a store before its translation is done, and a design that ignored this would drain an untranslated store. In a third, a fully ready store sits behind a head still waiting for data, and a design that skipped ahead would break program order. Ready patterns with holes, such as 101 or 010, carry pointers that name real entries. A design that did not gate them would make stores senior early and drain them too soon. Flushes are mixed with senior prefixes, drains and pending fences. A wrong tail restore then shows up as a wrong `alloc_sbid`. A fence that counted the same-cycle drain or allocation would pulse one store early or late.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_DRAIN = 2'd1,
        F_READY = 2'd2
    } fence_state_e;
endpackage

// File: rtl/sb_retire_match.sv
module sb_retire_match #(
    parameter int DEPTH = 16,
    parameter int ROBW  = 7,
    parameter int NRET  = 3
) (
    input  logic [NRET-1:0]       ret_ready,
    input  logic [NRET*ROBW-1:0]  ret_rob,
    input  logic [DEPTH*ROBW-1:0] ent_rob,
    input  logic [DEPTH-1:0]      elig,
    output logic                  pat_ok,
    output logic [DEPTH-1:0]      hit
);
    logic [NRET-1:0] active;

    // contiguous run of ones from the oldest pointer
    assign pat_ok = (ret_ready != '0) &&
                    ((ret_ready & (ret_ready + NRET'(1))) == '0);
    assign active = pat_ok ? ret_ready : '0;

    always_comb begin
        hit = '0;
        for (int e = 0; e < DEPTH; e++) begin
            for (int k = 0; k < NRET; k++) begin
                if (active[k] &&
                    ret_rob[k*ROBW +: ROBW] == ent_rob[e*ROBW +: ROBW]) begin
                    hit[e] = elig[e];
                end
            end
        end
    end
endmodule

// File: rtl/sb_fence_ctrl.sv
module sb_fence_ctrl
    import sb_pkg::*;
#(
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fence_req,
    input  logic            flush,
    input  logic            drain_fire,
    input  logic [CNTW-1:0] occ,
    output logic            fence_ready
);
    fence_state_e    state_q, state_d;
    logic [CNTW-1:0] rem_q, rem_d;
    logic [CNTW-1:0] older;

    assign older = occ - CNTW'(drain_fire);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            F_IDLE: begin
                if (fence_req && !flush) begin
                    rem_d   = older;
                    state_d = (older == '0) ? F_READY : F_DRAIN;
                end
            end
            F_DRAIN: begin
                if (flush) begin
                    state_d = F_IDLE;
                end else if (drain_fire) begin
                    rem_d = rem_q - CNTW'(1);
                    if (rem_q == CNTW'(1)) state_d = F_READY;
                end
            end
            F_READY: state_d = F_IDLE;
            default: state_d = F_IDLE;
        endcase
    end

    always_comb begin
        fence_ready = (state_q == F_READY);
    end

    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ready |=> !fence_ready);
    a_r8_flush_cancels_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_DRAIN && flush) |=> state_q == F_IDLE);
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer #(
    parameter int DEPTH = 16,
    parameter int ROBW  = 7,
    parameter int TAGW  = 20,
    parameter int DATAW = 32,
    parameter int NRET  = 3,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = IDXW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [ROBW-1:0]      alloc_rob_id,
    output logic [IDXW-1:0]      alloc_sbid,
    output logic                 sb_full,
    output logic                 sb_empty,
    input  logic                 addr_valid_in,
    input  logic [IDXW-1:0]      addr_sbid,
    input  logic [TAGW-1:0]      addr_tag,
    input  logic                 data_valid_in,
    input  logic [IDXW-1:0]      data_sbid,
    input  logic [DATAW-1:0]     data_value,
    input  logic [NRET-1:0]      ret_ready,
    input  logic [NRET*ROBW-1:0] ret_rob,
    input  logic                 flush,
    output logic                 cache_req,
    output logic [IDXW-1:0]      cache_sbid,
    output logic [TAGW-1:0]      cache_tag,
    output logic [DATAW-1:0]     cache_data,
    input  logic                 cache_done,
    input  logic                 fence_req,
    output logic                 fence_ready
);
    // per-entry state; DEPTH must be a power of two so indices wrap
    logic [DEPTH-1:0] vld_q, av_q, dv_q, sa_q, sd_q;
    logic [ROBW-1:0]  rob_q  [DEPTH];
    logic [TAGW-1:0]  tag_q  [DEPTH];
    logic [DATAW-1:0] data_q [DEPTH];
    logic [IDXW-1:0]  head_q, tail_q;
    logic [CNTW-1:0]  cnt_q;

    logic [DEPTH*ROBW-1:0] rob_flat;
    logic [DEPTH-1:0]      elig, ret_hit;
    logic                  pat_ok;
    logic                  alloc_fire, drain_fire;
    logic [CNTW-1:0]       sen_cnt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign rob_flat[g*ROBW +: ROBW] = rob_q[g];
    end

    assign elig = vld_q & av_q & ~sa_q & {DEPTH{~flush}};

    sb_retire_match #(.DEPTH(DEPTH), .ROBW(ROBW), .NRET(NRET)) u_match (
        .ret_ready (ret_ready),
        .ret_rob   (ret_rob),
        .ent_rob   (rob_flat),
        .elig      (elig),
        .pat_ok    (pat_ok),
        .hit       (ret_hit)
    );

    assign sb_full    = (cnt_q == CNTW'(DEPTH));
    assign sb_empty   = (cnt_q == '0);
    assign alloc_sbid = tail_q;
    assign alloc_fire = alloc_valid & ~sb_full & ~flush;

    assign cache_req  = vld_q[head_q] & sa_q[head_q] & sd_q[head_q] &
                        av_q[head_q] & dv_q[head_q];
    assign cache_sbid = head_q;
    assign cache_tag  = tag_q[head_q];
    assign cache_data = data_q[head_q];
    assign drain_fire = cache_req & cache_done;

    assign sen_cnt = CNTW'($countones(vld_q & sa_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            av_q   <= '0;
            dv_q   <= '0;
            sa_q   <= '0;
            sd_q   <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                rob_q[i]  <= '0;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (addr_valid_in && addr_sbid == IDXW'(i) && vld_q[i]) begin
                    av_q[i]  <= 1'b1;
                    tag_q[i] <= addr_tag;
                end
                if (data_valid_in && data_sbid == IDXW'(i) && vld_q[i]) begin
                    dv_q[i]   <= 1'b1;
                    data_q[i] <= data_value;
                end
                if (ret_hit[i]) begin
                    sa_q[i] <= 1'b1;
                    sd_q[i] <= 1'b1;
                end
            end
            if (drain_fire) begin
                vld_q[head_q] <= 1'b0;
                av_q[head_q]  <= 1'b0;
                dv_q[head_q]  <= 1'b0;
                sa_q[head_q]  <= 1'b0;
                sd_q[head_q]  <= 1'b0;
                head_q        <= head_q + IDXW'(1);
            end
            if (alloc_fire) begin
                vld_q[tail_q] <= 1'b1;
                av_q[tail_q]  <= 1'b0;
                dv_q[tail_q]  <= 1'b0;
                sa_q[tail_q]  <= 1'b0;
                sd_q[tail_q]  <= 1'b0;
                rob_q[tail_q] <= alloc_rob_id;
                tail_q        <= tail_q + IDXW'(1);
            end
            if (flush) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!sa_q[i]) begin
                        vld_q[i] <= 1'b0;
                        av_q[i]  <= 1'b0;
                        dv_q[i]  <= 1'b0;
                        sd_q[i]  <= 1'b0;
                    end
                end
                tail_q <= head_q + sen_cnt[IDXW-1:0];
                cnt_q  <= sen_cnt - CNTW'(drain_fire);
            end else begin
                cnt_q <= cnt_q + CNTW'(alloc_fire) - CNTW'(drain_fire);
            end
        end
    end

    sb_fence_ctrl #(.CNTW(CNTW)) u_fence (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_req   (fence_req),
        .flush       (flush),
        .drain_fire  (drain_fire),
        .occ         (cnt_q),
        .fence_ready (fence_ready)
    );

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DEPTH));
    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_full && !drain_fire && !flush) |=> sb_full);
    a_r2_senior_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q & sa_q & ~av_q) == '0);
    a_r3_no_retire_unless_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        !pat_ok |=> ((sa_q & ~$past(sa_q)) == '0));
    a_r5_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req && !cache_done) |=> (cache_req && $stable(cache_sbid)));
    a_r6_head_advances: assert property (@(posedge clk) disable iff (!rst_n)
        drain_fire |=> head_q == IDXW'($past(head_q) + IDXW'(1)));
endmodule

// File: tb/sb_store_buffer_test.sv
module sb_store_buffer_test;
    localparam int DEPTH = 16;
    localparam int ROBW  = 7;
    localparam int TAGW  = 20;
    localparam int DATAW = 32;
    localparam int NRET  = 3;
    localparam int IDXW  = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic alloc_valid;
    logic [ROBW-1:0] alloc_rob_id;
    logic [IDXW-1:0] alloc_sbid;
    logic sb_full, sb_empty;
    logic addr_valid_in;
    logic [IDXW-1:0] addr_sbid;
    logic [TAGW-1:0] addr_tag;
    logic data_valid_in;
    logic [IDXW-1:0] data_sbid;
    logic [DATAW-1:0] data_value;
    logic [NRET-1:0] ret_ready;
    logic [NRET*ROBW-1:0] ret_rob;
    logic flush;
    logic cache_req;
    logic [IDXW-1:0] cache_sbid;
    logic [TAGW-1:0] cache_tag;
    logic [DATAW-1:0] cache_data;
    logic cache_done;
    logic fence_req;
    logic fence_ready;

    always #5 clk = ~clk;

    sb_store_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_rob_id(alloc_rob_id),
        .alloc_sbid(alloc_sbid), .sb_full(sb_full), .sb_empty(sb_empty),
        .addr_valid_in(addr_valid_in), .addr_sbid(addr_sbid), .addr_tag(addr_tag),
        .data_valid_in(data_valid_in), .data_sbid(data_sbid), .data_value(data_value),
        .ret_ready(ret_ready), .ret_rob(ret_rob), .flush(flush),
        .cache_req(cache_req), .cache_sbid(cache_sbid), .cache_tag(cache_tag),
        .cache_data(cache_data), .cache_done(cache_done),
        .fence_req(fence_req), .fence_ready(fence_ready)
    );

    typedef struct {
        int sbid; int rob; bit av; int tag; bit dv; int data; bit sen;
    } ent_t;

    ent_t q[$];
    int m_head, m_tail, m_rob, fst, frem;
    int checks, fails;
    bit finished;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit er;
        er = q.size() > 0 && q[0].sen && q[0].av && q[0].dv;
        chk(int'(alloc_sbid) == m_tail, "R1 R8", "alloc_sbid", alloc_sbid, m_tail);
        chk(sb_full == (q.size() == DEPTH), "R9", "sb_full", sb_full, q.size() == DEPTH);
        chk(sb_empty == (q.size() == 0), "R9", "sb_empty", sb_empty, q.size() == 0);
        chk(cache_req == er, "R2 R3 R4 R5", "cache_req", cache_req, er);
        if (er && cache_req) begin
            chk(int'(cache_sbid) == q[0].sbid, "R5 R6", "cache_sbid", cache_sbid, q[0].sbid);
            chk(int'(cache_tag) == q[0].tag, "R1 R2", "cache_tag", cache_tag, q[0].tag);
            chk(int'(cache_data) == q[0].data, "R1 R4", "cache_data", cache_data, q[0].data);
        end
        chk(fence_ready == (fst == 2), "R7", "fence_ready", fence_ready, fst == 2);
    endtask

    task automatic model_update();
        int sz, n;
        bit drain;
        sz = q.size();
        drain = sz > 0 && q[0].sen && q[0].av && q[0].dv && cache_done;
        case (fst)
            0: if (fence_req && !flush) begin
                   frem = sz - int'(drain);
                   fst = (frem == 0) ? 2 : 1;
               end
            1: if (flush) fst = 0;
               else if (drain) begin
                   frem--;
                   if (frem == 0) fst = 2;
               end
            default: fst = 0;
        endcase
        n = 0;
        if (!flush) begin
            case (ret_ready)
                3'b001: n = 1;
                3'b011: n = 2;
                3'b111: n = 3;
                default: n = 0;
            endcase
        end
        for (int k = 0; k < n; k++) begin
            int p;
            p = int'(ret_rob[k*ROBW +: ROBW]);
            foreach (q[j]) if (q[j].rob == p && q[j].av && !q[j].sen) q[j].sen = 1;
        end
        if (addr_valid_in)
            foreach (q[j]) if (q[j].sbid == int'(addr_sbid)) begin
                q[j].av = 1; q[j].tag = int'(addr_tag);
            end
        if (data_valid_in)
            foreach (q[j]) if (q[j].sbid == int'(data_sbid)) begin
                q[j].dv = 1; q[j].data = int'(data_value);
            end
        if (drain) begin
            void'(q.pop_front());
            m_head = (m_head + 1) % DEPTH;
        end
        if (alloc_valid && sz < DEPTH && !flush) begin
            ent_t e;
            e = '{sbid: m_tail, rob: int'(alloc_rob_id), av: 0, tag: 0, dv: 0, data: 0, sen: 0};
            q.push_back(e);
            m_tail = (m_tail + 1) % DEPTH;
            m_rob = (m_rob + 1) % 128;
        end
        if (flush) begin
            while (q.size() > 0 && !q[q.size()-1].sen) void'(q.pop_back());
            m_tail = (q.size() > 0) ? (q[q.size()-1].sbid + 1) % DEPTH : m_head;
        end
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic gen(int pa, int pdone, int pflush, int pret);
        int f, m;
        int cand[$];
        alloc_valid  = ($urandom % 100) < pa;
        alloc_rob_id = ROBW'(m_rob);
        cand.delete();
        foreach (q[j]) if (!q[j].av) cand.push_back(q[j].sbid);
        addr_valid_in = cand.size() > 0 && ($urandom % 100) < 40;
        addr_sbid = (cand.size() > 0) ? IDXW'(cand[$urandom % cand.size()]) : '0;
        addr_tag  = TAGW'($urandom);
        cand.delete();
        foreach (q[j]) if (!q[j].dv) cand.push_back(q[j].sbid);
        data_valid_in = cand.size() > 0 && ($urandom % 100) < 40;
        data_sbid  = (cand.size() > 0) ? IDXW'(cand[$urandom % cand.size()]) : '0;
        data_value = $urandom;
        // first non-senior entry and how many leading ones are translated
        f = q.size();
        foreach (q[j]) if (!q[j].sen && f == q.size()) f = j;
        m = 0;
        for (int j = f; j < q.size() && m < 3 && q[j].av; j++) m++;
        ret_ready = '0;
        for (int k = 0; k < NRET; k++)
            ret_rob[k*ROBW +: ROBW] = (f + k < q.size()) ? ROBW'(q[f+k].rob) : ROBW'($urandom);
        if (m > 0 && ($urandom % 100) < pret) begin
            int kk;
            kk = 1 + ($urandom % m);
            ret_ready = NRET'((1 << kk) - 1);
        end else if (($urandom % 100) < 30) begin
            int bad[4] = '{2, 4, 5, 6};
            ret_ready = NRET'(bad[$urandom % 4]); // R3 gapped pattern, must not retire
        end else if (f < q.size() && !q[f].av && ($urandom % 100) < 40) begin
            ret_ready = 3'b001; // R2 pointer hits untranslated store
        end
        cache_done = ($urandom % 100) < pdone;
        fence_req  = ($urandom % 100) < 5;
        flush      = ($urandom % 1000) < pflush;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        checks = 0; fails = 0; finished = 0;
        m_head = 0; m_tail = 0; m_rob = 0; fst = 0; frem = 0;
        rst_n = 0;
        alloc_valid = 0; alloc_rob_id = '0;
        addr_valid_in = 0; addr_sbid = '0; addr_tag = '0;
        data_valid_in = 0; data_sbid = '0; data_value = '0;
        ret_ready = '0; ret_rob = '0; flush = 0; cache_done = 0; fence_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk(sb_empty && !sb_full, "R10", "empty/full after reset", {sb_empty, sb_full}, 2'b10);
        chk(alloc_sbid == '0, "R10", "alloc_sbid after reset", alloc_sbid, 0);
        chk(!cache_req && !fence_ready, "R10", "req/fence after reset", {cache_req, fence_ready}, 0);
        @(negedge clk);
        // fill phase: mostly allocation, rare drain
        for (int c = 0; c < 600; c++) begin gen(85, 10, 5, 40); step(); end
        // balanced traffic
        for (int c = 0; c < 1200; c++) begin gen(50, 60, 10, 60); step(); end
        // flush heavy with slow cache
        for (int c = 0; c < 800; c++) begin gen(60, 30, 60, 70); step(); end
        // drain-heavy, fences see emptying queue
        for (int c = 0; c < 600; c++) begin gen(20, 90, 5, 80); step(); end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule